// File: doc/BRIEF.md
# Registered SECDED Decoder for One Byte

This block receives a 13-bit protected word that carries one data byte and five check bits. It recomputes the Hamming check bits and the overall parity, forms a 5-bit syndrome, and repairs any single flipped data bit. The repaired byte and three status flags go into an output register.

The status flags are error-detected, error-corrected and fatal. They cover data-bit faults only. A lone fault in a check bit is repaired silently: the flags stay low and the byte is delivered as received. A double fault cannot be repaired, so the byte passes through unchanged with the detected and fatal flags raised.

An active-high asynchronous clear empties the output register at once, without waiting for a clock. A consumer can pulse it to discard a result it has just seen flagged as fatal.

Top module: `secded_dec13`

## Requirements
- R1: Word layout. Bits 7:0 hold data bits d0..d7, which take Hamming positions 3,5,6,7,9,10,11,12. Bits 8,9,10,11 hold the check bits for positions 1,2,4,8. Each check bit is the XOR of the data bits whose position has that weight. Bit 12 makes the parity of all 13 bits even. For example, 0x14F0 is the clean word for byte 0xF0.
- R2: A clean word is delivered with its low byte unchanged and all three flags low.
- R3: A single flipped data bit is inverted back, so the original byte is delivered. Detected and corrected are high and fatal is low.
- R4: A single flipped check bit (bits 8..12) gives the received byte with all three flags low. This includes the overall parity bit alone.
- R5: Two flipped bits anywhere in the word give the received byte uncorrected. Detected and fatal are high and corrected is low.
- R6: Odd overall parity combined with a position syndrome of 13, 14 or 15 gives the received byte uncorrected. Detected and fatal are high and corrected is low.
- R7: Data and flags are registered. They show the word that was present at the previous rising clock edge and do not change between edges.
- R8: While clear is high, the byte and all flags are zero, even with no clock edge. After clear falls, they stay zero until the next rising edge.
- R9: Corrected is never high without detected. Corrected and fatal are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clear | input | 1 | Asynchronous clear, active high |
| code_in | input | 13 | Received protected word |
| data_out | output | 8 | Registered, corrected data byte |
| err_det | output | 1 | Registered error-detected flag |
| err_corr | output | 1 | Registered error-corrected flag |
| err_fatal | output | 1 | Registered uncorrectable-error flag |

## Verification
On every clocked cycle, the assertions check the following:
- the flag combinations are legal;
- an unflagged or fatal result carries exactly the low byte of the previous word;
- a corrected result differs from the received byte in exactly one bit;
- the outputs are zero while clear is high.

Only the bench scenarios can show whether the delivered byte is the right one and which fault class each word falls into. For this, the bench builds words with its own encoder and sweeps all 256 bytes under these fault patterns:
- no fault;
- every single flip;
- a double flip;
- all 78 double-flip pairs on selected bytes;
- the out-of-range position patterns.

The bench also checks the timing of the asynchronous clear and the one-cycle register delay.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef struct packed {
    logic det;
    logic corr;
    logic fatal;
  } flags_t;

  // Hamming position of data bit idx: the idx-th integer >= 3 that is not a power of two
  function automatic int data_pos(int idx);
    int n;
    int res;
    n   = 0;
    res = 0;
    for (int k = 3; k < 256; k++) begin
      if (res == 0 && (k & (k - 1)) != 0) begin
        if (n == idx) res = k;
        n++;
      end
    end
    return res;
  endfunction

  // Set of data bits covered by the check bit of weight 2**j
  function automatic logic [63:0] cover_mask(int j, int dw);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < dw; i++) begin
      if (((data_pos(i) >> j) & 1) != 0) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/secded_syndrome.sv
module secded_syndrome #(
  parameter int DATA_W = 8,
  parameter int PAR_W  = 4
) (
  input  logic [DATA_W+PAR_W:0] cw,
  output logic [PAR_W-1:0]      syn_pos,
  output logic                  syn_odd
);
  import secded_pkg::*;

  localparam int CW_W = DATA_W + PAR_W + 1;

  // Position syndrome: recomputed check bit XOR received check bit
  for (genvar j = 0; j < PAR_W; j++) begin : g_chk
    localparam logic [63:0] MASK = cover_mask(j, DATA_W);
    always_comb begin
      syn_pos[j] = cw[DATA_W + j] ^ (^(cw[DATA_W-1:0] & MASK[DATA_W-1:0]));
    end
  end

  // Overall parity over the whole word; odd means an odd number of flips
  always_comb begin
    syn_odd = ^cw[CW_W-1:0];
  end

endmodule

// File: rtl/secded_correct.sv
module secded_correct #(
  parameter int DATA_W = 8,
  parameter int PAR_W  = 4
) (
  input  logic [DATA_W-1:0]       data_rx,
  input  logic [PAR_W-1:0]        syn_pos,
  input  logic                    syn_odd,
  output logic [DATA_W-1:0]       data_fix,
  output secded_pkg::flags_t      flags
);
  import secded_pkg::*;

  localparam int MAX_POS = data_pos(DATA_W - 1);

  logic [DATA_W-1:0] flip;
  logic              pos_nz;
  logic              pos_high;

  // One comparator per data bit against its Hamming position
  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    localparam int P = data_pos(i);
    always_comb begin
      flip[i] = syn_odd && (syn_pos == PAR_W'(P));
    end
  end

  always_comb begin
    pos_nz      = |syn_pos;
    pos_high    = int'(syn_pos) > MAX_POS;
    data_fix    = data_rx ^ flip;
    flags.corr  = |flip;
    flags.fatal = (!syn_odd && pos_nz) || (syn_odd && pos_high);
    flags.det   = flags.corr || flags.fatal;
  end

  // R3: at most one data bit is ever inverted
  always_comb begin
    a_one_flip_r3: assert ($onehot0(flip));
  end

endmodule

// File: rtl/secded_outreg.sv
module secded_outreg #(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 clear,
  input  logic [DATA_W-1:0]    data_d,
  input  secded_pkg::flags_t   flags_d,
  output logic [DATA_W-1:0]    data_q,
  output secded_pkg::flags_t   flags_q
);
  import secded_pkg::*;

  logic [DATA_W-1:0] data_nx;
  flags_t            flags_nx;

  always_comb begin
    data_nx  = data_d;
    flags_nx = flags_d;
  end

  always_ff @(posedge clk or posedge clear) begin
    if (clear) begin
      data_q  <= '0;
      flags_q <= '0;
    end else begin
      data_q  <= data_nx;
      flags_q <= flags_nx;
    end
  end

  p_clear_zero_r8: assert property (@(posedge clk)
    clear |-> (data_q == '0 && flags_q == '0));

  p_corr_legal_r9: assert property (@(posedge clk) disable iff (clear)
    flags_q.corr |-> (flags_q.det && !flags_q.fatal));

  p_fatal_det_r9: assert property (@(posedge clk) disable iff (clear)
    flags_q.fatal |-> flags_q.det);

endmodule

// File: rtl/secded_dec13.sv
module secded_dec13 #(
  parameter int DATA_W = 8,
  parameter int PAR_W  = 4
) (
  input  logic                  clk,
  input  logic                  clear,
  input  logic [DATA_W+PAR_W:0] code_in,
  output logic [DATA_W-1:0]     data_out,
  output logic                  err_det,
  output logic                  err_corr,
  output logic                  err_fatal
);
  import secded_pkg::*;

  logic [PAR_W-1:0]  syn_pos;
  logic              syn_odd;
  logic [DATA_W-1:0] data_fix;
  flags_t            flags_c;
  flags_t            flags_q;

  secded_syndrome #(.DATA_W(DATA_W), .PAR_W(PAR_W)) i_syn (
    .cw      (code_in),
    .syn_pos (syn_pos),
    .syn_odd (syn_odd)
  );

  secded_correct #(.DATA_W(DATA_W), .PAR_W(PAR_W)) i_fix (
    .data_rx  (code_in[DATA_W-1:0]),
    .syn_pos  (syn_pos),
    .syn_odd  (syn_odd),
    .data_fix (data_fix),
    .flags    (flags_c)
  );

  secded_outreg #(.DATA_W(DATA_W)) i_reg (
    .clk     (clk),
    .clear   (clear),
    .data_d  (data_fix),
    .flags_d (flags_c),
    .data_q  (data_out),
    .flags_q (flags_q)
  );

  always_comb begin
    err_det   = flags_q.det;
    err_corr  = flags_q.corr;
    err_fatal = flags_q.fatal;
  end

  // Marks that the output register has taken at least one word since clear
  logic primed;
  always_ff @(posedge clk or posedge clear) begin
    if (clear) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  p_pass_nodet_r4: assert property (@(posedge clk) disable iff (clear)
    (primed && !err_det) |-> (data_out == $past(code_in[DATA_W-1:0])));

  p_fatal_pass_r5: assert property (@(posedge clk) disable iff (clear)
    (primed && err_fatal) |-> (data_out == $past(code_in[DATA_W-1:0])));

  p_corr_onebit_r3: assert property (@(posedge clk) disable iff (clear)
    (primed && err_corr) |->
      ($countones(data_out ^ $past(code_in[DATA_W-1:0])) == 1));

endmodule

// File: tb/test_secded_dec13.sv
module test_secded_dec13;

  logic        clk = 1'b0;
  logic        clear;
  logic [12:0] code_in;
  logic [7:0]  data_out;
  logic        err_det;
  logic        err_corr;
  logic        err_fatal;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  secded_dec13 i_secded_dec13 (
    .clk       (clk),
    .clear     (clear),
    .code_in   (code_in),
    .data_out  (data_out),
    .err_det   (err_det),
    .err_corr  (err_corr),
    .err_fatal (err_fatal)
  );

  function automatic logic [12:0] encode(logic [7:0] d);
    int pos [8] = '{3, 5, 6, 7, 9, 10, 11, 12};
    logic [3:0] p;
    p = '0;
    for (int j = 0; j < 4; j++)
      for (int i = 0; i < 8; i++)
        if (((pos[i] >> j) & 1) != 0) p[j] = p[j] ^ d[i];
    return {^{p, d}, p, d};
  endfunction

  task automatic expect_out(string req, logic [7:0] ed, logic edet, logic ecorr, logic efat);
    checks++;
    if ({data_out, err_det, err_corr, err_fatal} !== {ed, edet, ecorr, efat}) begin
      errors++;
      $display("FAIL %s: got data=%h det=%b corr=%b fatal=%b, expected data=%h det=%b corr=%b fatal=%b",
               req, data_out, err_det, err_corr, err_fatal, ed, edet, ecorr, efat);
    end
  endtask

  task automatic apply(logic [12:0] w);
    @(negedge clk);
    code_in = w;
    @(negedge clk);
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [12:0] w;
    int sel [4] = '{0, 8'hF0, 8'hA5, 8'hFF};
    clear   = 1'b0;
    code_in = '0;
    #1 clear = 1'b1;
    repeat (3) @(negedge clk);
    expect_out("R8 reset", 8'h00, 0, 0, 0);
    clear = 1'b0;

    // R1: the clean word for byte 0xF0
    checks++;
    if (encode(8'hF0) !== 13'h14F0) begin
      errors++;
      $display("FAIL R1: got %h expected 14f0", encode(8'hF0));
    end
    apply(13'h14F0);
    expect_out("R1 word 14F0", 8'hF0, 0, 0, 0);
    apply(13'h14F1);
    expect_out("R3 word 14F1", 8'hF0, 1, 1, 0);
    apply(13'h14F3);
    expect_out("R5 word 14F3", 8'hF3, 1, 0, 1);

    for (int d = 0; d < 256; d++) begin
      w = encode(8'(d));
      apply(w);
      expect_out("R2 clean", 8'(d), 0, 0, 0);
      for (int b = 0; b < 13; b++) begin
        apply(w ^ (13'd1 << b));
        if (b < 8) expect_out("R3 data flip", 8'(d), 1, 1, 0);
        else       expect_out("R4 check flip", 8'(d), 0, 0, 0);
      end
      begin
        int b1 = d % 13;
        int b2 = (d + 5) % 13;
        logic [12:0] e;
        e = w ^ (13'd1 << b1) ^ (13'd1 << b2);
        apply(e);
        expect_out("R5 double", e[7:0], 1, 0, 1);
      end
    end

    foreach (sel[s]) begin
      w = encode(8'(sel[s]));
      for (int a = 0; a < 13; a++)
        for (int b = a + 1; b < 13; b++) begin
          logic [12:0] e;
          e = w ^ (13'd1 << a) ^ (13'd1 << b);
          apply(e);
          expect_out("R5 pair", e[7:0], 1, 0, 1);
        end
      // R6: odd parity with position 13, 14 and 15
      begin
        logic [12:0] e;
        e = w ^ 13'h1000 ^ 13'h0100 ^ 13'h0080;
        apply(e);
        expect_out("R6 pos13", e[7:0], 1, 0, 1);
        e = w ^ 13'h1000 ^ 13'h0200 ^ 13'h0080;
        apply(e);
        expect_out("R6 pos14", e[7:0], 1, 0, 1);
        e = w ^ 13'h1000 ^ 13'h0001 ^ 13'h0080;
        apply(e);
        expect_out("R6 pos15", e[7:0], 1, 0, 1);
      end
    end

    // R7: an input change shows nothing before the next rising edge
    apply(encode(8'h3C));
    expect_out("R7 settle", 8'h3C, 0, 0, 0);
    code_in = encode(8'hC3) ^ 13'h0004;
    #1;
    expect_out("R7 hold", 8'h3C, 0, 0, 0);
    @(negedge clk);
    expect_out("R7 update", 8'hC3, 1, 1, 0);

    // R8: asynchronous clear between edges, zero until the next edge after release
    apply(encode(8'h5A) ^ 13'h0003);
    expect_out("R8 before", 8'h5B ^ 8'h01 ^ 8'h02 ^ 8'h01, 1, 0, 1);
    #0.5 clear = 1'b1;
    #0.5;
    expect_out("R8 immediate", 8'h00, 0, 0, 0);
    @(negedge clk);
    #1 clear = 1'b0;
    #0.5;
    expect_out("R8 held", 8'h00, 0, 0, 0);
    @(negedge clk);
    expect_out("R8 resume", 8'h59, 1, 0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule